// File: doc/BRIEF.md
# Per-Process Active Node Tracker

This block keeps a count, for every process slot and every memory node, of the pages that process currently has mapped in that node. A node is active for a process exactly when its count is nonzero. The active bits of one process form a vector with one bit per node. Page map and unmap events arrive one per cycle as a process id and a node id. Each event moves exactly one counter by one step. After each event, the block reports the updated active vector of the process that the event named.

When the scheduler signals a context switch, it supplies two process ids: the process about to run and the process expected to run after it. One cycle later the block returns the bitwise OR of the active vectors of those two processes. The power controller uses this mask to bring the listed memory nodes out of nap into standby ahead of use. The block does not decide the scheduling order and does not drive the memory chips.

Top module: `active_node_tracker`

## Requirements
- R1: After reset every counter is zero, and act_valid_o, act_vec_o, err_o, wake_valid_o and wake_mask_o are all zero.
- R2: A map event (evt_kind_i = 0) increments only the counter selected by evt_pid_i and evt_node_i. The active vectors of all other processes are unchanged.
- R3: A counter holds at its maximum, 2^CNT_W-1 (255 by default), and never wraps. After more map events than that maximum, exactly that maximum number of unmap events returns the node to inactive.
- R4: Bit n of a process's active vector is 1 exactly when that process's counter for node n is nonzero. With two pages mapped and one unmapped, the node stays active.
- R5: An unmap event (evt_kind_i = 1) on a zero counter drives err_o high in the next cycle and leaves the counter at zero. A later single map followed by a single unmap therefore leaves the node inactive.
- R6: One cycle after any event, act_valid_o is 1 and act_vec_o holds the post-update active vector of evt_pid_i. In a cycle with no event, act_valid_o is 0 in the next cycle and act_vec_o keeps its value.
- R7: One cycle after sw_valid_i, wake_valid_o is 1 and wake_mask_o equals the OR of the active vectors of sw_next_pid_i and sw_after_pid_i. Bit n of the mask stands for node n.
- R8: When an event and a switch request occur in the same cycle, the wake mask uses the counter values from before that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_valid_i | input | 1 | A map or unmap event is present this cycle |
| evt_kind_i | input | 1 | 0 = map, 1 = unmap |
| evt_pid_i | input | PID_W | Process slot of the event |
| evt_node_i | input | NID_W | Memory node of the event |
| sw_valid_i | input | 1 | Context-switch request |
| sw_next_pid_i | input | PID_W | Process about to run |
| sw_after_pid_i | input | PID_W | Process likely to run after it |
| act_valid_o | output | 1 | act_vec_o was updated by the previous cycle's event |
| act_vec_o | output | NUM_NODES | Active-node vector of the last event's process |
| err_o | output | 1 | Unmap was requested on a zero counter in the previous cycle |
| wake_valid_o | output | 1 | wake_mask_o answers the previous cycle's switch request |
| wake_mask_o | output | NUM_NODES | Nodes to raise from nap to standby |

## Verification
The hardest state to reach from the ports is a saturated counter. Reaching it takes 255 consecutive map events to one process and node. The bench then sends more maps beyond that point and counts the unmaps back down one at a time. It checks that the node is still active after 254 unmaps, goes inactive at the 255th, and signals an error at the next unmap. A second hard case is an event and a switch request on the same edge. The bench drives both together for a process with no pages, so a mask that used the updated count would show the node.

// File: rtl/ant_pkg.sv
package ant_pkg;
  typedef enum logic {
    EV_MAP   = 1'b0,
    EV_UNMAP = 1'b1
  } ant_evt_e;
endpackage

// File: rtl/ant_node_counter.sv
module ant_node_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_en_i,
  input  logic             dec_en_i,
  output logic             live_o,
  output logic             live_next_o,
  output logic             underflow_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d       = cnt_q;
    underflow_o = 1'b0;
    if (inc_en_i && !dec_en_i) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end else if (dec_en_i && !inc_en_i) begin
      if (cnt_q == '0) underflow_o = 1'b1;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (inc_en_i || dec_en_i) cnt_q <= cnt_d;
  end

  assign live_o      = (cnt_q != '0);
  assign live_next_o = (cnt_d != '0);

  // R3: a full counter stays full on a further increment
  p_no_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && inc_en_i && !dec_en_i) |=> (cnt_q == CNT_MAX));

  // R5: decrement of an empty counter leaves it empty
  p_zero_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && dec_en_i && !inc_en_i) |=> (cnt_q == '0));

  // R2: the count only moves in a cycle that had an enable
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> $past(inc_en_i || dec_en_i));
endmodule

// File: rtl/ant_vec_pick.sv
module ant_vec_pick #(
  parameter int NUM_PROCS = 8,
  parameter int NUM_NODES = 16,
  parameter int PID_W     = 3
) (
  input  logic [NUM_PROCS-1:0][NUM_NODES-1:0] vecs_i,
  input  logic [PID_W-1:0]                    pid_i,
  output logic [NUM_NODES-1:0]                vec_o
);
  always_comb begin
    vec_o = '0;
    for (int p = 0; p < NUM_PROCS; p++) begin
      if (pid_i == PID_W'(p)) vec_o = vecs_i[p];
    end
  end
endmodule

// File: rtl/active_node_tracker.sv
module active_node_tracker
  import ant_pkg::*;
#(
  parameter int NUM_PROCS = 8,
  parameter int NUM_NODES = 16,
  parameter int CNT_W     = 8,
  localparam int PID_W    = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1,
  localparam int NID_W    = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 evt_valid_i,
  input  logic                 evt_kind_i,
  input  logic [PID_W-1:0]     evt_pid_i,
  input  logic [NID_W-1:0]     evt_node_i,
  input  logic                 sw_valid_i,
  input  logic [PID_W-1:0]     sw_next_pid_i,
  input  logic [PID_W-1:0]     sw_after_pid_i,
  output logic                 act_valid_o,
  output logic [NUM_NODES-1:0] act_vec_o,
  output logic                 err_o,
  output logic                 wake_valid_o,
  output logic [NUM_NODES-1:0] wake_mask_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic is_map, is_unmap;
  assign is_map   = evt_valid_i && (ant_evt_e'(evt_kind_i) == EV_MAP);
  assign is_unmap = evt_valid_i && (ant_evt_e'(evt_kind_i) == EV_UNMAP);

  logic [NUM_PROCS-1:0][NUM_NODES-1:0] live, live_next, uflow;

  for (genvar p = 0; p < NUM_PROCS; p++) begin : g_proc
    for (genvar n = 0; n < NUM_NODES; n++) begin : g_node
      logic hit;
      assign hit = (evt_pid_i == PID_W'(p)) && (evt_node_i == NID_W'(n));
      ant_node_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i       (clk_i),
        .rst_ni      (rst_n),
        .inc_en_i    (is_map && hit),
        .dec_en_i    (is_unmap && hit),
        .live_o      (live[p][n]),
        .live_next_o (live_next[p][n]),
        .underflow_o (uflow[p][n])
      );
    end
  end

  logic [NUM_NODES-1:0] evt_vec, next_vec, after_vec;

  ant_vec_pick #(.NUM_PROCS(NUM_PROCS), .NUM_NODES(NUM_NODES), .PID_W(PID_W)) u_pick_evt (
    .vecs_i (live_next), .pid_i (evt_pid_i), .vec_o (evt_vec));
  ant_vec_pick #(.NUM_PROCS(NUM_PROCS), .NUM_NODES(NUM_NODES), .PID_W(PID_W)) u_pick_next (
    .vecs_i (live), .pid_i (sw_next_pid_i), .vec_o (next_vec));
  ant_vec_pick #(.NUM_PROCS(NUM_PROCS), .NUM_NODES(NUM_NODES), .PID_W(PID_W)) u_pick_after (
    .vecs_i (live), .pid_i (sw_after_pid_i), .vec_o (after_vec));

  logic [NUM_NODES-1:0] act_vec_d, wake_mask_d;

  always_comb begin
    act_vec_d   = act_vec_o;
    wake_mask_d = wake_mask_o;
    if (evt_valid_i) act_vec_d   = evt_vec;
    if (sw_valid_i)  wake_mask_d = next_vec | after_vec;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      act_valid_o  <= 1'b0;
      err_o        <= 1'b0;
      wake_valid_o <= 1'b0;
    end else begin
      act_valid_o  <= evt_valid_i;
      err_o        <= |uflow;
      wake_valid_o <= sw_valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)           act_vec_o <= '0;
    else if (evt_valid_i) act_vec_o <= act_vec_d;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)          wake_mask_o <= '0;
    else if (sw_valid_i) wake_mask_o <= wake_mask_d;
  end

  // R6: every event yields a valid vector next cycle
  p_act_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    evt_valid_i |=> act_valid_o);

  // R6: the vector holds while no event arrives
  p_act_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    !evt_valid_i |=> $stable(act_vec_o));

  // R2: a map leaves its node active for that process
  p_map_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    is_map |=> act_vec_o[$past(evt_node_i)]);

  // R5: an error only follows an unmap
  p_err_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_o |-> $past(is_unmap));

  // R7: each switch request is answered next cycle
  p_wake_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    sw_valid_i |=> wake_valid_o);
endmodule

// File: tb/active_node_tracker_tb_top.sv
module active_node_tracker_tb_top;
  localparam int NP = 8;
  localparam int NN = 16;
  localparam int CMAX = 255;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0, evt_kind = 1'b0;
  logic [2:0]  evt_pid = '0;
  logic [3:0]  evt_node = '0;
  logic        sw_valid = 1'b0;
  logic [2:0]  sw_next = '0, sw_after = '0;
  logic        act_valid, err, wake_valid;
  logic [15:0] act_vec, wake_mask;

  int checks = 0, failures = 0;
  int cnt [NP][NN];

  always #5 clk = ~clk;

  active_node_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_valid_i(evt_valid), .evt_kind_i(evt_kind), .evt_pid_i(evt_pid), .evt_node_i(evt_node),
    .sw_valid_i(sw_valid), .sw_next_pid_i(sw_next), .sw_after_pid_i(sw_after),
    .act_valid_o(act_valid), .act_vec_o(act_vec), .err_o(err),
    .wake_valid_o(wake_valid), .wake_mask_o(wake_mask)
  );

  function automatic logic [15:0] vec_of(int p);
    logic [15:0] v = '0;
    for (int n = 0; n < NN; n++) v[n] = (cnt[p][n] != 0);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one event; checks vector (R6) and error flag (R5)
  task automatic ev(input bit unmap, input int p, input int n);
    bit exp_err = 1'b0;
    @(negedge clk);
    evt_valid = 1'b1; evt_kind = unmap; evt_pid = 3'(p); evt_node = 4'(n);
    if (!unmap) begin
      if (cnt[p][n] < CMAX) cnt[p][n]++;
    end else begin
      if (cnt[p][n] == 0) exp_err = 1'b1;
      else cnt[p][n]--;
    end
    @(negedge clk);
    evt_valid = 1'b0;
    check(act_valid == 1'b1, "R6 act_valid", 16'(act_valid), 16'd1);
    check(act_vec == vec_of(p), "R6 act_vec", act_vec, vec_of(p));
    check(err == exp_err, "R5 err", 16'(err), 16'(exp_err));
  endtask

  task automatic sw(input int a, input int b);
    logic [15:0] exp;
    @(negedge clk);
    sw_valid = 1'b1; sw_next = 3'(a); sw_after = 3'(b);
    exp = vec_of(a) | vec_of(b);
    @(negedge clk);
    sw_valid = 1'b0;
    check(wake_valid == 1'b1, "R7 wake_valid", 16'(wake_valid), 16'd1);
    check(wake_mask == exp, "R7 wake_mask", wake_mask, exp);
  endtask

  task automatic t_reset_r1();
    check(act_valid == 1'b0 && err == 1'b0 && wake_valid == 1'b0, "R1 flags",
          {13'd0, act_valid, err, wake_valid}, 16'd0);
    check(act_vec == '0, "R1 act_vec", act_vec, 16'd0);
    check(wake_mask == '0, "R1 wake_mask", wake_mask, 16'd0);
    sw(3, 7);
  endtask

  task automatic t_map_r2();
    ev(0, 1, 3);
    ev(0, 1, 3);
    ev(0, 2, 15);
    ev(0, 1, 0);
    sw(1, 1);   // R2: process 1 does not see process 2's node
    sw(2, 2);
    sw(0, 7);   // R2: untouched processes remain empty
  endtask

  task automatic t_live_r4();
    ev(1, 1, 3);
    check(act_vec[3] == 1'b1, "R4 still active", act_vec, vec_of(1));
    ev(1, 1, 3);
    check(act_vec[3] == 1'b0, "R4 inactive", act_vec, vec_of(1));
  endtask

  task automatic t_underflow_r5();
    ev(1, 4, 7);
    check(err == 1'b1, "R5 err on zero", 16'(err), 16'd1);
    ev(0, 4, 7);
    ev(1, 4, 7);
    check(act_vec[7] == 1'b0 && err == 1'b0, "R5 no wrap", act_vec, 16'd0);
  endtask

  task automatic t_sat_r3();
    for (int i = 0; i < CMAX + 40; i++) ev(0, 5, 0);
    for (int i = 0; i < CMAX - 1; i++) ev(1, 5, 0);
    check(act_vec[0] == 1'b1, "R3 active before last", act_vec, 16'd1);
    ev(1, 5, 0);
    check(act_vec[0] == 1'b0, "R3 inactive at max unmaps", act_vec, 16'd0);
    ev(1, 5, 0);
    check(err == 1'b1, "R3 error after drain", 16'(err), 16'd1);
  endtask

  task automatic t_idle_r6();
    logic [15:0] held;
    held = act_vec;
    @(negedge clk);
    check(act_valid == 1'b0, "R6 idle valid", 16'(act_valid), 16'd0);
    check(act_vec == held, "R6 hold", act_vec, held);
  endtask

  task automatic t_union_r7();
    ev(0, 3, 2); ev(0, 3, 9); ev(0, 7, 9); ev(0, 7, 14);
    sw(3, 7);
    sw(7, 1);
    sw(3, 3);
    sw(6, 5);
  endtask

  task automatic t_same_cycle_r8();
    @(negedge clk);
    evt_valid = 1'b1; evt_kind = 1'b0; evt_pid = 3'd6; evt_node = 4'd11;
    sw_valid = 1'b1; sw_next = 3'd6; sw_after = 3'd6;
    @(negedge clk);
    evt_valid = 1'b0; sw_valid = 1'b0;
    check(wake_mask == 16'd0, "R8 mask uses old counts", wake_mask, 16'd0);
    check(act_vec == 16'h0800, "R8 event still applied", act_vec, 16'h0800);
    cnt[6][11] = 1;
    sw(6, 0);
  endtask

  initial begin
    for (int p = 0; p < NP; p++)
      for (int n = 0; n < NN; n++) cnt[p][n] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_r1();
    t_map_r2();
    t_live_r4();
    t_underflow_r5();
    t_sat_r3();
    t_idle_r6();
    t_union_r7();
    t_same_cycle_r8();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule